// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Controller

This block keeps one 32-bit control/status word for each channel of a multi-channel DMA engine and folds the per-channel event flags into a per-channel pending summary and one interrupt line. Software writes a channel word to load its control bits, to clear sticky event flags by writing ones, and to set or clear the compare flag by command bits. The transfer engine raises event flags through per-channel event strobes. Reads are combinational: the selected channel word comes back with a live request-pending bit merged in.

Stop, end-of-receive and request-after-stop flags reach the interrupt only when their own enable bit is set; start and end flags reach it with no enable. A write that sets neither run nor mask-run forces the stop flag. The pending summary follows the stored words, and the interrupt output is a register that changes on the same clock edge as the words it summarises.

Top module: `dmacs_status_top`

## Requirements
- R1: After reset every channel word reads 0x00000008 (only the stop flag, bit 3), `pend_summary` is all zero and `irq` is 0.
- R2: A write to a channel keeps status bits 0, 1, 2, 3, 4, 9 and 10 and discards all other stored bits; a 1 written at bit 0 (bus error), 1 (start), 2 (end) or 9 (end of receive) clears that flag, while a written 1 at bit 3, 4 or 10 does not clear it.
- R3: A write loads bits 31..26 and bit 23 from the written value; bits 5..7 and 11..22 always read 0 (mask-run, bit 22, is never stored).
- R4: Stop rules on a write, applied in this order: stop-interrupt enable (bit 29) set in the new word clears stop; a written run (bit 31) clears stop; a write with both run and mask-run (bit 22) at 0 sets stop, overriding the two rules before it.
- R5: A written 1 at bit 24 clears the compare flag (bit 10) and a written 1 at bit 25 sets it; when both are 1 the flag ends set.
- R6: Engine event strobes set bus error (bit 0), start (1), end (2), stop (3), request-after-stop (4) and end of receive (9) of their channel in the same edge as, and after, any write to that channel.
- R7: A channel's stop, end-of-receive and request-after-stop flags count as pending only when bit 29, bit 28 or bit 23 respectively is also 1.
- R8: A channel's start and end flags count as pending with no enable.
- R9: `pend_summary[c]` is the OR of the pending conditions of channel c's stored word.
- R10: `irq` is a register equal to the OR of all `pend_summary` bits, updated on the same edge as the channel words.
- R11: `rd_data` returns the word of channel `rd_ch` with bit 8 equal to the current `req_active[rd_ch]`.
- R12: A write to one channel leaves every other channel word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for channel word `wr_ch` |
| wr_ch | input | CHW | Channel addressed by the write |
| wr_data | input | 32 | Written value |
| rd_ch | input | CHW | Channel selected for read |
| rd_data | output | 32 | Selected word with request-pending merged at bit 8 |
| req_active | input | NCH | Live request input per channel |
| ev_berr | input | NCH | Engine sets bus error flag |
| ev_start | input | NCH | Engine sets start flag |
| ev_end | input | NCH | Engine sets end flag |
| ev_stop | input | NCH | Engine sets stop flag |
| ev_ras | input | NCH | Engine sets request-after-stop flag |
| ev_eor | input | NCH | Engine sets end-of-receive flag |
| pend_summary | output | NCH | Per-channel pending summary |
| irq | output | 1 | Registered interrupt |

## Verification
The assertions take the channel count to be a power of two so that every `wr_ch` value names a real channel, and the run-clears-stop check assumes the engine does not raise a stop event on the same channel in the same cycle; the bench keeps the default eight channels and masks that case out of the property rather than out of the stimulus. Stimulus mixes random write values, sparse random event strobes and toggling request inputs with directed writes for the compare set/clear collision, the forced stop, and enable gating, while a bench model of the word predicts every channel after each edge.

// File: rtl/dmacs_pkg.sv
// Package: shared bit positions, masks and event type for the DMA
// channel status block. Assumes 32-bit channel words.
package dmacs_pkg;
    localparam int STW       = 32;
    localparam int B_BERR    = 0;
    localparam int B_START   = 1;
    localparam int B_END     = 2;
    localparam int B_STOP    = 3;
    localparam int B_RAS     = 4;
    localparam int B_REQ     = 8;
    localparam int B_EOR     = 9;
    localparam int B_CMP     = 10;
    localparam int B_MRUN    = 22;
    localparam int B_RASEN   = 23;
    localparam int B_CMPCLR  = 24;
    localparam int B_CMPSET  = 25;
    localparam int B_EOREN   = 28;
    localparam int B_STOPEN  = 29;
    localparam int B_RUN     = 31;

    // Status bits retained across a write (request-pending is never stored).
    localparam logic [STW-1:0] KEEP_M  = 32'h0000_061F;
    // Flags cleared by a written one.
    localparam logic [STW-1:0] W1C_M   = 32'h0000_0207;
    // Control bits loaded from the written value.
    localparam logic [STW-1:0] LOAD_M  = 32'hFC80_0000;
    localparam logic [STW-1:0] RESET_V = 32'h0000_0008;

    typedef struct packed {
        logic berr;
        logic start;
        logic done;
        logic stop;
        logic ras;
        logic eor;
    } evt_t;
endpackage

// File: rtl/dmacs_src_gate.sv
// Module: turns the flag/enable bits of one channel word into its five
// interrupt contributions. Purely combinational.
module dmacs_src_gate (
    input  logic       stop_f,
    input  logic       stop_en,
    input  logic       eor_f,
    input  logic       eor_en,
    input  logic       ras_f,
    input  logic       ras_en,
    input  logic       start_f,
    input  logic       end_f,
    output logic [4:0] contrib
);
    // Gated sources need their enable; start and end pass straight through.
    always_comb begin
        contrib[0] = stop_f & stop_en;
        contrib[1] = eor_f & eor_en;
        contrib[2] = ras_f & ras_en;
        contrib[3] = start_f;
        contrib[4] = end_f;
    end
endmodule

// File: rtl/dmacs_chan_reg.sv
// Module: one channel status word. Applies software write semantics,
// then ORs in engine events, and reports the interrupt contributions of
// both the stored and the next word. Assumes wr_hit is already decoded.
module dmacs_chan_reg
    import dmacs_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_hit,
    input  logic [STW-1:0] wr_val,
    input  evt_t           evt,
    output logic [STW-1:0] stat_q,
    output logic [4:0]     contrib_q,
    output logic [4:0]     contrib_d
);
    logic [STW-1:0] stat_d;

    // Next-state: write semantics first, then engine events on top.
    always_comb begin
        stat_d = stat_q;
        if (wr_hit) begin
            stat_d = (stat_q & KEEP_M) & ~(wr_val & W1C_M);
            stat_d = stat_d | (wr_val & LOAD_M);
            if (stat_d[B_STOPEN])
                stat_d[B_STOP] = 1'b0;
            if (wr_val[B_RUN])
                stat_d[B_STOP] = 1'b0;
            if (!wr_val[B_RUN] && !wr_val[B_MRUN])
                stat_d[B_STOP] = 1'b1;
            if (wr_val[B_CMPCLR])
                stat_d[B_CMP] = 1'b0;
            if (wr_val[B_CMPSET])
                stat_d[B_CMP] = 1'b1;
        end
        if (evt.berr)  stat_d[B_BERR]  = 1'b1;
        if (evt.start) stat_d[B_START] = 1'b1;
        if (evt.done)  stat_d[B_END]   = 1'b1;
        if (evt.stop)  stat_d[B_STOP]  = 1'b1;
        if (evt.ras)   stat_d[B_RAS]   = 1'b1;
        if (evt.eor)   stat_d[B_EOR]   = 1'b1;
    end

    // Word register with reset to stop-only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= RESET_V;
        else
            stat_q <= stat_d;
    end

    dmacs_src_gate u_gate_q (
        .stop_f (stat_q[B_STOP]),  .stop_en(stat_q[B_STOPEN]),
        .eor_f  (stat_q[B_EOR]),   .eor_en (stat_q[B_EOREN]),
        .ras_f  (stat_q[B_RAS]),   .ras_en (stat_q[B_RASEN]),
        .start_f(stat_q[B_START]), .end_f  (stat_q[B_END]),
        .contrib(contrib_q)
    );

    dmacs_src_gate u_gate_d (
        .stop_f (stat_d[B_STOP]),  .stop_en(stat_d[B_STOPEN]),
        .eor_f  (stat_d[B_EOR]),   .eor_en (stat_d[B_EOREN]),
        .ras_f  (stat_d[B_RAS]),   .ras_en (stat_d[B_RASEN]),
        .start_f(stat_d[B_START]), .end_f  (stat_d[B_END]),
        .contrib(contrib_d)
    );
endmodule

// File: rtl/dmacs_irq_reg.sv
// Module: registered OR of the next-state pending bits of all channels,
// so the line moves on the same edge as the channel words.
module dmacs_irq_reg #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend_next,
    output logic           irq
);
    // Interrupt flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= |pend_next;
    end
endmodule

// File: rtl/dmacs_status_top.sv
// Module: DMA channel status and interrupt controller top. Instantiates
// one status word per channel, the read mux with live request-pending,
// the pending summary and the interrupt register. Assumes NCH >= 2.
module dmacs_status_top
    import dmacs_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_ch,
    input  logic [31:0]    wr_data,
    input  logic [CHW-1:0] rd_ch,
    output logic [31:0]    rd_data,
    input  logic [NCH-1:0] req_active,
    input  logic [NCH-1:0] ev_berr,
    input  logic [NCH-1:0] ev_start,
    input  logic [NCH-1:0] ev_end,
    input  logic [NCH-1:0] ev_stop,
    input  logic [NCH-1:0] ev_ras,
    input  logic [NCH-1:0] ev_eor,
    output logic [NCH-1:0] pend_summary,
    output logic           irq
);
    logic [NCH-1:0][STW-1:0] chan_stat;
    logic [NCH-1:0]          pend_next;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [4:0] cq;
        logic [4:0] cd;
        evt_t       ev;
        assign ev = '{berr: ev_berr[c], start: ev_start[c], done: ev_end[c],
                      stop: ev_stop[c], ras: ev_ras[c], eor: ev_eor[c]};
        dmacs_chan_reg u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (wr_en && (int'(wr_ch) == c)),
            .wr_val   (wr_data),
            .evt      (ev),
            .stat_q   (chan_stat[c]),
            .contrib_q(cq),
            .contrib_d(cd)
        );
        assign pend_summary[c] = |cq;
        assign pend_next[c]    = |cd;
    end

    // Read mux: selected word with the live request bit merged in.
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (int'(rd_ch) == c) begin
                rd_data        = chan_stat[c];
                rd_data[B_REQ] = req_active[c];
            end
        end
    end

    dmacs_irq_reg #(.NCH(NCH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_next(pend_next),
        .irq      (irq)
    );
endmodule

// File: rtl/dmacs_status_chk.sv
// Module: assertion checker bound to dmacs_status_top. Assumes a
// power-of-two channel count so every wr_ch names a channel.
module dmacs_status_chk #(
    parameter int NCH = 8,
    localparam int CHW = $clog2(NCH)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [CHW-1:0]       wr_ch,
    input logic [31:0]          wr_data,
    input logic [CHW-1:0]       rd_ch,
    input logic [31:0]          rd_data,
    input logic [NCH-1:0]       req_active,
    input logic [NCH-1:0]       ev_stop,
    input logic [NCH-1:0]       pend_summary,
    input logic                 irq,
    input logic [NCH-1:0][31:0] chan_stat
);
    logic [CHW-1:0] last_ch;
    logic [31:0]    last_stat;

    // Remember the channel written last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) last_ch <= '0;
        else        last_ch <= wr_ch;
    end
    assign last_stat = chan_stat[last_ch];

    p_irq_summary_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|pend_summary));
    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & 32'h007F_F8E0) == 32'h0);
    p_req_merge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[8] == req_active[rd_ch]);
    p_stop_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[31] && !wr_data[22]) |=> last_stat[3]);
    p_run_clears_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31] && !ev_stop[wr_ch]) |=> !last_stat[3]);
    p_cmp_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25]) |=> last_stat[10]);
    p_cmp_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[24] && !wr_data[25]) |=> !last_stat[10]);
endmodule

bind dmacs_status_top dmacs_status_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_data(wr_data), .rd_ch(rd_ch), .rd_data(rd_data),
    .req_active(req_active), .ev_stop(ev_stop),
    .pend_summary(pend_summary), .irq(irq), .chan_stat(chan_stat)
);

// File: tb/sim_dmacs_status_top.sv
`timescale 1ns/1ps
module sim_dmacs_status_top;
    localparam int NCH = 8;
    localparam int CHW = $clog2(NCH);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [CHW-1:0] wr_ch = '0;
    logic [31:0]    wr_data = '0;
    logic [CHW-1:0] rd_ch = '0;
    logic [31:0]    rd_data;
    logic [NCH-1:0] req_active = '0;
    logic [NCH-1:0] ev_berr = '0, ev_start = '0, ev_end = '0;
    logic [NCH-1:0] ev_stop = '0, ev_ras = '0, ev_eor = '0;
    logic [NCH-1:0] pend_summary;
    logic           irq;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_st [NCH];

    always #10 clk = ~clk;

    dmacs_status_top #(.NCH(NCH)) u0 (.*);

    // Word after a software write, from R2..R5.
    function automatic logic [31:0] m_write(logic [31:0] old, logic [31:0] v);
        logic [31:0] r;
        r = old & 32'h0000_061F;
        if (v[0]) r[0] = 1'b0;
        if (v[1]) r[1] = 1'b0;
        if (v[2]) r[2] = 1'b0;
        if (v[9]) r[9] = 1'b0;
        r = r | (v & 32'hFC80_0000);
        if (r[29]) r[3] = 1'b0;
        if (v[31]) r[3] = 1'b0;
        if (!v[31] && !v[22]) r[3] = 1'b1;
        if (v[24]) r[10] = 1'b0;
        if (v[25]) r[10] = 1'b1;
        return r;
    endfunction

    // Pending condition of a word, from R7..R9.
    function automatic logic m_pend(logic [31:0] s);
        return (s[3] & s[29]) | (s[9] & s[28]) | (s[4] & s[23]) | s[1] | s[2];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // One clock: model follows the driven inputs, then inputs go idle.
    task automatic tick();
        @(posedge clk);
        for (int c = 0; c < NCH; c++) begin
            if (wr_en && int'(wr_ch) == c) exp_st[c] = m_write(exp_st[c], wr_data);
            if (ev_berr[c])  exp_st[c][0] = 1'b1;
            if (ev_start[c]) exp_st[c][1] = 1'b1;
            if (ev_end[c])   exp_st[c][2] = 1'b1;
            if (ev_stop[c])  exp_st[c][3] = 1'b1;
            if (ev_ras[c])   exp_st[c][4] = 1'b1;
            if (ev_eor[c])   exp_st[c][9] = 1'b1;
        end
        @(negedge clk);
        wr_en = 1'b0;
        {ev_berr, ev_start, ev_end, ev_stop, ev_ras, ev_eor} = '0;
    endtask

    task automatic wr(input int ch, input logic [31:0] v);
        wr_en = 1'b1; wr_ch = CHW'(ch); wr_data = v;
        tick();
    endtask

    // Compare every channel, the summary and irq with the model.
    task automatic check_all(input string tag);
        logic [NCH-1:0] ps;
        for (int c = 0; c < NCH; c++) begin
            logic [31:0] e;
            rd_ch = CHW'(c);
            #1;
            e = exp_st[c];
            e[8] = req_active[c];
            chk({tag, " R2 R3 R6 R11 R12 word"}, rd_data, e);
            ps[c] = m_pend(exp_st[c]);
        end
        chk({tag, " R9 summary"}, 32'(pend_summary), 32'(ps));
        chk({tag, " R10 irq"}, 32'(irq), 32'(|ps));
    endtask

    logic done = 1'b0;
    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int c = 0; c < NCH; c++) exp_st[c] = 32'h0000_0008;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_ch = '0; #1;
        chk("R1 reset word", rd_data, 32'h0000_0008);
        chk("R1 reset summary", 32'(pend_summary), 32'h0);
        chk("R1 reset irq", 32'(irq), 32'h0);
        check_all("R1");

        // R5: set and clear together, set wins
        wr(0, 32'h8300_0000);
        rd_ch = 0; #1;
        chk("R5 both cmp cmds", 32'(rd_data[10]), 32'h1);
        wr(0, 32'h8100_0000);
        rd_ch = 0; #1;
        chk("R5 clear cmp", 32'(rd_data[10]), 32'h0);

        // R4: no run and no mask-run forces stop, even with stop enable
        wr(1, 32'h2000_0000);
        rd_ch = 1; #1;
        chk("R4 forced stop", 32'(rd_data[3]), 32'h1);
        chk("R4 R7 stop gated in", 32'(pend_summary[1]), 32'h1);
        wr(1, 32'h0040_0000);
        rd_ch = 1; #1;
        chk("R4 mask-run keeps stop", 32'(rd_data[3]), 32'h1);
        chk("R7 stop without enable", 32'(pend_summary[1]), 32'h0);
        wr(1, 32'h8000_0000);
        rd_ch = 1; #1;
        chk("R4 run clears stop", 32'(rd_data[3]), 32'h0);

        // R7: request-after-stop needs its enable
        ev_ras[2] = 1'b1; tick();
        chk("R7 ras ungated", 32'(pend_summary[2]), 32'h0);
        wr(2, 32'h8080_0000);
        chk("R7 ras enabled", 32'(pend_summary[2]), 32'h1);
        chk("R10 irq raised", 32'(irq), 32'h1);

        // R8: start flag pends with no enable; R2 write-one clears it
        ev_start[3] = 1'b1; tick();
        chk("R8 start pends", 32'(pend_summary[3]), 32'h1);
        wr(3, 32'h8000_0002);
        chk("R2 w1c start", 32'(pend_summary[3]), 32'h0);

        // R6: event after write in same cycle
        wr_en = 1'b1; wr_ch = 3'd4; wr_data = 32'h8000_0004; ev_end[4] = 1'b1;
        tick();
        rd_ch = 4; #1;
        chk("R6 event beats w1c", 32'(rd_data[2]), 32'h1);

        // R11: live request bit
        req_active = 8'h10; rd_ch = 4; #1;
        chk("R11 request merged", 32'(rd_data[8]), 32'h1);
        req_active = 8'h00; #1;
        chk("R11 request dropped", 32'(rd_data[8]), 32'h0);
        check_all("directed");

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] v;
            if ($urandom % 10 < 4) begin
                v = $urandom;
                if ($urandom % 4 == 0) v = v & 32'h7FBF_FFFF;
                wr_en = 1'b1; wr_ch = CHW'($urandom); wr_data = v;
            end
            for (int c = 0; c < NCH; c++) begin
                ev_berr[c]  = ($urandom % 16) == 0;
                ev_start[c] = ($urandom % 16) == 0;
                ev_end[c]   = ($urandom % 16) == 0;
                ev_stop[c]  = ($urandom % 16) == 0;
                ev_ras[c]   = ($urandom % 16) == 0;
                ev_eor[c]   = ($urandom % 16) == 0;
            end
            if ($urandom % 8 == 0) req_active = NCH'($urandom);
            tick();
            check_all("random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule